// File: doc/BRIEF.md
# Programmable Asynchronous Memory Strobe Sequencer

This block runs access cycles on one asynchronous external memory chip select. A host presents a request with an address, a direction flag, write data and a word count. The block checks that the address falls inside the chip-select region. It then runs a cycle in which the chip-select, address-valid, output-enable and write-enable strobes each switch at their own programmed tick. A tick is one period of the functional clock after division by 1 to 4.

Each tick value is a small count measured from the start of the cycle. Chip select and address-valid each have one assert tick and two deassert ticks, one for reads and one for writes. Read and write cycles have separate total lengths. Read data is captured at a programmed access tick. In a multi-word read, each later word is captured a programmed number of ticks after the one before, and the memory address steps by one for each word. The timing set is copied into a snapshot when a request is accepted, so changes on the configuration inputs cannot disturb a cycle already running.

Top module: `amem_timing_engine`

## Requirements
- R1: After reset, and whenever `req_ready_o` is high, all four strobes are high (inactive), `mem_wdata_oe_o` is low and `rsp_done_o` is low outside a response pulse.
- R2: A request is in the region when `req_addr_i[31:24]` equals `cfg_base_i` zero-extended, which places the region on a 16 MB boundary. A request outside the region starts no cycle: one clock after acceptance, `rsp_done_o` and `rsp_err_o` pulse high together for one clock.
- R3: `mem_cs_n_o` is low exactly while the tick count c satisfies on <= c < off. Here on is `cfg_cs_on_i` (4 bits), and off is `cfg_cs_rd_off_i` for reads and `cfg_cs_wr_off_i` for writes (5 bits). If off <= on, the strobe never goes low.
- R4: `mem_avld_n_o` follows the same rule as R3, using `cfg_avld_on_i` with `cfg_avld_rd_off_i` or `cfg_avld_wr_off_i`.
- R5: `mem_oe_n_o` follows the window rule with `cfg_oe_on_i`/`cfg_oe_off_i`, but only in read cycles. `mem_we_n_o` follows it with `cfg_we_on_i`/`cfg_we_off_i`, but only in write cycles. The two are never low together.
- R6: A cycle starts on the clock after acceptance with tick count 0. It stays busy (`req_ready_o` low) until the clock on which the count first equals the cycle length (`cfg_rd_len_i` or `cfg_wr_len_i`). `rsp_done_o` then pulses for one clock, and `req_ready_o` is high again in that clock.
- R7: Each tick lasts `cfg_div_i`+1 clocks. The 2-bit field holds the divisor minus one, so a cycle of length L occupies L*(`cfg_div_i`+1)+1 busy clocks.
- R8: In read cycles, `mem_rdata_i` is sampled on the first clock of tick `cfg_access_i`. The sampled value appears on `rdata_o`, with `rdata_valid_o` high, one clock later.
- R9: A read carries `req_words_i`+1 words. Word k is captured at tick `cfg_access_i` + k*max(`cfg_page_gap_i`,1). `mem_addr_o` equals the request's low 24 address bits plus the number of words captured so far. Captures that would fall after the cycle ends are dropped, and writes carry a single word.
- R10: Throughout a write cycle, `mem_wdata_oe_o` is high and `mem_wdata_o` holds the request's write data.
- R11: All timing fields, including the divider, are captured at acceptance. Changes on the configuration inputs during a cycle have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Idle; a present request is accepted this clock |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte/word address of the request |
| req_wdata_i | input | DATA_W | Write data |
| req_words_i | input | WORDS_W | Read word count minus one |
| cfg_cs_on_i | input | 4 | Chip-select assert tick |
| cfg_cs_rd_off_i | input | 5 | Chip-select deassert tick, reads |
| cfg_cs_wr_off_i | input | 5 | Chip-select deassert tick, writes |
| cfg_avld_on_i | input | 4 | Address-valid assert tick |
| cfg_avld_rd_off_i | input | 5 | Address-valid deassert tick, reads |
| cfg_avld_wr_off_i | input | 5 | Address-valid deassert tick, writes |
| cfg_oe_on_i | input | 4 | Output-enable assert tick |
| cfg_oe_off_i | input | 5 | Output-enable deassert tick |
| cfg_we_on_i | input | 4 | Write-enable assert tick |
| cfg_we_off_i | input | 5 | Write-enable deassert tick |
| cfg_rd_len_i | input | 5 | Read cycle length in ticks |
| cfg_wr_len_i | input | 5 | Write cycle length in ticks |
| cfg_access_i | input | 5 | Tick of first read data capture |
| cfg_page_gap_i | input | 4 | Ticks between later read words |
| cfg_div_i | input | 2 | Clock divisor minus one |
| cfg_base_i | input | 5 | Region base, address bits 28:24 |
| rsp_done_o | output | 1 | One-clock completion pulse |
| rsp_err_o | output | 1 | Out-of-region rejection, with done |
| rdata_valid_o | output | 1 | Read word valid on rdata_o |
| rdata_o | output | DATA_W | Captured read word |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_avld_n_o | output | 1 | Address valid, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_addr_o | output | REGION_SH | Address inside the region |
| mem_wdata_o | output | DATA_W | Write data to memory |
| mem_wdata_oe_o | output | 1 | Write data drive enable |
| mem_rdata_i | input | DATA_W | Read data from memory |

## Verification
A wrong tick counter or a stalled divider shifts every strobe edge. The chip-select or enable pins then disagree with the expected pattern within one tick of the fault, well before `rsp_done_o`. A corrupted capture pointer shows up as a missing, extra or misplaced `rdata_valid_o` pulse, or as a word that does not match the data the memory model returns for the current `mem_addr_o`. A stuck busy state shows up as a `req_ready_o` that stays low, or as a completion pulse on the wrong clock, in the very first transaction after the fault.

// File: rtl/amem_pkg.sv
package amem_pkg;
  localparam int ON_W   = 4;
  localparam int OFF_W  = 5;
  localparam int LEN_W  = 5;
  localparam int ACC_W  = 5;
  localparam int GAP_W  = 4;
  localparam int DIV_W  = 2;
  localparam int BASE_W = 5;
  localparam int NSTB   = 4;

  typedef enum logic {ST_IDLE, ST_BUSY} amem_state_e;

  typedef struct packed {
    logic [ON_W-1:0]  cs_on;
    logic [OFF_W-1:0] cs_rd_off;
    logic [OFF_W-1:0] cs_wr_off;
    logic [ON_W-1:0]  avld_on;
    logic [OFF_W-1:0] avld_rd_off;
    logic [OFF_W-1:0] avld_wr_off;
    logic [ON_W-1:0]  oe_on;
    logic [OFF_W-1:0] oe_off;
    logic [ON_W-1:0]  we_on;
    logic [OFF_W-1:0] we_off;
    logic [LEN_W-1:0] rd_len;
    logic [LEN_W-1:0] wr_len;
    logic [ACC_W-1:0] access;
    logic [GAP_W-1:0] page_gap;
    logic [DIV_W-1:0] div;
  } amem_cfg_t;
endpackage

// File: rtl/amem_tick_div.sv
module amem_tick_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             first_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q, pre_d;

  assign tick_o  = run_i && (pre_q == div_i);
  assign first_o = (pre_q == '0);

  always_comb begin
    pre_d = pre_q;
    if (restart_i)   pre_d = '0;
    else if (tick_o) pre_d = '0;
    else if (run_i)  pre_d = pre_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end
endmodule

// File: rtl/amem_window.sv
module amem_window #(
  parameter int CNT_W = 5,
  parameter int ON_W  = 4,
  parameter int OFF_W = 5
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [ON_W-1:0]  on_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             act_o
);
  localparam int CMP_W = (CNT_W > OFF_W) ? CNT_W : OFF_W;
  logic [CMP_W-1:0] c_x, on_x, off_x;

  assign c_x   = CMP_W'(cnt_i);
  assign on_x  = CMP_W'(on_i);
  assign off_x = CMP_W'(off_i);
  assign act_o = en_i && (c_x >= on_x) && (c_x < off_x);
endmodule

// File: rtl/amem_capture.sv
module amem_capture #(
  parameter int DATA_W  = 16,
  parameter int WORDS_W = 3,
  parameter int CNT_W   = 5,
  parameter int ACC_W   = 5,
  parameter int GAP_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [WORDS_W-1:0] words_i,
  input  logic [ACC_W-1:0]   access_i,
  input  logic [GAP_W-1:0]   gap_i,
  input  logic               step_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic               rvalid_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [WORDS_W:0]   idx_o
);
  localparam int NXT_W = ACC_W + GAP_W + WORDS_W + 1;
  localparam int REM_W = WORDS_W + 1;

  logic [NXT_W-1:0]  nxt_q, nxt_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [REM_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              vld_q, vld_d;
  logic [GAP_W-1:0]  gap_eff;
  logic              hit;

  assign gap_eff = (gap_i == '0) ? GAP_W'(1) : gap_i;
  assign hit     = step_i && (rem_q != '0) && (NXT_W'(cnt_i) == nxt_q);

  always_comb begin
    nxt_d = nxt_q;
    rem_d = rem_q;
    idx_d = idx_q;
    dat_d = dat_q;
    vld_d = 1'b0;
    if (load_i) begin
      nxt_d = NXT_W'(access_i);
      rem_d = REM_W'(words_i) + REM_W'(1);
      idx_d = '0;
    end else if (hit) begin
      nxt_d = nxt_q + NXT_W'(gap_eff);
      rem_d = rem_q - REM_W'(1);
      idx_d = idx_q + REM_W'(1);
      dat_d = rdata_i;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q <= '0;
      rem_q <= '0;
      idx_q <= '0;
      dat_q <= '0;
      vld_q <= 1'b0;
    end else begin
      nxt_q <= nxt_d;
      rem_q <= rem_d;
      idx_q <= idx_d;
      dat_q <= dat_d;
      vld_q <= vld_d;
    end
  end

  assign rvalid_o = vld_q;
  assign rdata_o  = dat_q;
  assign idx_o    = idx_q;
endmodule

// File: rtl/amem_timing_engine.sv
module amem_timing_engine
  import amem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 16,
  parameter int WORDS_W   = 3,
  parameter int REGION_SH = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  input  logic [WORDS_W-1:0]   req_words_i,
  input  logic [ON_W-1:0]      cfg_cs_on_i,
  input  logic [OFF_W-1:0]     cfg_cs_rd_off_i,
  input  logic [OFF_W-1:0]     cfg_cs_wr_off_i,
  input  logic [ON_W-1:0]      cfg_avld_on_i,
  input  logic [OFF_W-1:0]     cfg_avld_rd_off_i,
  input  logic [OFF_W-1:0]     cfg_avld_wr_off_i,
  input  logic [ON_W-1:0]      cfg_oe_on_i,
  input  logic [OFF_W-1:0]     cfg_oe_off_i,
  input  logic [ON_W-1:0]      cfg_we_on_i,
  input  logic [OFF_W-1:0]     cfg_we_off_i,
  input  logic [LEN_W-1:0]     cfg_rd_len_i,
  input  logic [LEN_W-1:0]     cfg_wr_len_i,
  input  logic [ACC_W-1:0]     cfg_access_i,
  input  logic [GAP_W-1:0]     cfg_page_gap_i,
  input  logic [DIV_W-1:0]     cfg_div_i,
  input  logic [BASE_W-1:0]    cfg_base_i,
  output logic                 rsp_done_o,
  output logic                 rsp_err_o,
  output logic                 rdata_valid_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 mem_cs_n_o,
  output logic                 mem_avld_n_o,
  output logic                 mem_oe_n_o,
  output logic                 mem_we_n_o,
  output logic [REGION_SH-1:0] mem_addr_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  output logic                 mem_wdata_oe_o,
  input  logic [DATA_W-1:0]    mem_rdata_i
);
  localparam int HI_W  = ADDR_W - REGION_SH;
  localparam int CNT_W = LEN_W;

  amem_state_e          state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  amem_cfg_t            cfg_q, cfg_d, cfg_live;
  logic                 wr_q, wr_d;
  logic [DATA_W-1:0]    wdata_q, wdata_d;
  logic [REGION_SH-1:0] off_q, off_d;
  logic                 done_q, done_d, err_q, err_d;

  logic                 busy, accept, in_region, last, tick, first;
  logic [CNT_W-1:0]     len;
  logic [WORDS_W:0]     word_idx;

  logic [ON_W-1:0]      on_a  [NSTB];
  logic [OFF_W-1:0]     off_a [NSTB];
  logic                 en_a  [NSTB];
  logic [NSTB-1:0]      act;

  always_comb begin
    cfg_live.cs_on       = cfg_cs_on_i;
    cfg_live.cs_rd_off   = cfg_cs_rd_off_i;
    cfg_live.cs_wr_off   = cfg_cs_wr_off_i;
    cfg_live.avld_on     = cfg_avld_on_i;
    cfg_live.avld_rd_off = cfg_avld_rd_off_i;
    cfg_live.avld_wr_off = cfg_avld_wr_off_i;
    cfg_live.oe_on       = cfg_oe_on_i;
    cfg_live.oe_off      = cfg_oe_off_i;
    cfg_live.we_on       = cfg_we_on_i;
    cfg_live.we_off      = cfg_we_off_i;
    cfg_live.rd_len      = cfg_rd_len_i;
    cfg_live.wr_len      = cfg_wr_len_i;
    cfg_live.access      = cfg_access_i;
    cfg_live.page_gap    = cfg_page_gap_i;
    cfg_live.div         = cfg_div_i;
  end

  assign busy      = (state_q == ST_BUSY);
  assign accept    = req_valid_i && !busy;
  assign in_region = (req_addr_i[ADDR_W-1:REGION_SH] == HI_W'(cfg_base_i));
  assign len       = wr_q ? cfg_q.wr_len : cfg_q.rd_len;
  assign last      = busy && (cnt_q == len);

  amem_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (accept),
    .run_i     (busy),
    .div_i     (cfg_q.div),
    .first_o   (first),
    .tick_o    (tick)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cfg_d   = cfg_q;
    wr_d    = wr_q;
    wdata_d = wdata_q;
    off_d   = off_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    if (accept) begin
      if (in_region) begin
        state_d = ST_BUSY;
        cnt_d   = '0;
        cfg_d   = cfg_live;
        wr_d    = req_write_i;
        wdata_d = req_wdata_i;
        off_d   = req_addr_i[REGION_SH-1:0];
      end else begin
        done_d = 1'b1;
        err_d  = 1'b1;
      end
    end else if (busy) begin
      if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end else if (tick) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cfg_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      off_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cfg_q   <= cfg_d;
      wr_q    <= wr_d;
      wdata_q <= wdata_d;
      off_q   <= off_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // strobe order: 0 chip select, 1 address valid, 2 output enable, 3 write enable
  always_comb begin
    on_a[0]  = cfg_q.cs_on;
    off_a[0] = wr_q ? cfg_q.cs_wr_off : cfg_q.cs_rd_off;
    en_a[0]  = busy;
    on_a[1]  = cfg_q.avld_on;
    off_a[1] = wr_q ? cfg_q.avld_wr_off : cfg_q.avld_rd_off;
    en_a[1]  = busy;
    on_a[2]  = cfg_q.oe_on;
    off_a[2] = cfg_q.oe_off;
    en_a[2]  = busy && !wr_q;
    on_a[3]  = cfg_q.we_on;
    off_a[3] = cfg_q.we_off;
    en_a[3]  = busy && wr_q;
  end

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    amem_window #(.CNT_W(CNT_W), .ON_W(ON_W), .OFF_W(OFF_W)) u_win (
      .en_i  (en_a[g]),
      .cnt_i (cnt_q),
      .on_i  (on_a[g]),
      .off_i (off_a[g]),
      .act_o (act[g])
    );
  end

  amem_capture #(
    .DATA_W(DATA_W), .WORDS_W(WORDS_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .GAP_W(GAP_W)
  ) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept && in_region),
    .words_i  (req_words_i),
    .access_i (cfg_access_i),
    .gap_i    (cfg_q.page_gap),
    .step_i   (busy && first && !wr_q),
    .cnt_i    (cnt_q),
    .rdata_i  (mem_rdata_i),
    .rvalid_o (rdata_valid_o),
    .rdata_o  (rdata_o),
    .idx_o    (word_idx)
  );

  assign req_ready_o    = !busy;
  assign rsp_done_o     = done_q;
  assign rsp_err_o      = err_q;
  assign mem_cs_n_o     = !act[0];
  assign mem_avld_n_o   = !act[1];
  assign mem_oe_n_o     = !act[2];
  assign mem_we_n_o     = !act[3];
  assign mem_addr_o     = off_q + REGION_SH'(word_idx);
  assign mem_wdata_o    = wdata_q;
  assign mem_wdata_oe_o = busy && wr_q;
endmodule

// File: rtl/amem_timing_engine_chk.sv
module amem_timing_engine_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_done_o,
  input logic              rsp_err_o,
  input logic              rdata_valid_o,
  input logic              mem_cs_n_o,
  input logic              mem_avld_n_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_wdata_oe_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_cs_n_o && mem_avld_n_o && mem_oe_n_o && mem_we_n_o && !mem_wdata_oe_o));

  p_err_with_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_done_o && mem_cs_n_o));

  p_oe_we_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_n_o && !mem_we_n_o));

  p_done_after_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o && !rsp_err_o) |-> $past(!req_ready_o));

  p_rvalid_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> ($past(mem_we_n_o) && $past(!req_ready_o)));

  p_wdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wdata_oe_o && $past(mem_wdata_oe_o)) |-> $stable(mem_wdata_o));
endmodule

bind amem_timing_engine amem_timing_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_ready_o    (req_ready_o),
  .rsp_done_o     (rsp_done_o),
  .rsp_err_o      (rsp_err_o),
  .rdata_valid_o  (rdata_valid_o),
  .mem_cs_n_o     (mem_cs_n_o),
  .mem_avld_n_o   (mem_avld_n_o),
  .mem_oe_n_o     (mem_oe_n_o),
  .mem_we_n_o     (mem_we_n_o),
  .mem_wdata_o    (mem_wdata_o),
  .mem_wdata_oe_o (mem_wdata_oe_o)
);

// File: tb/amem_timing_engine_tb_top.sv
module amem_timing_engine_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 16;
  localparam int WORDS_W = 3;
  localparam int RSH = 24;

  typedef struct packed {
    logic cs, avld, oe, we, rdv, done, err, rdy, woe;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] wdata;
  } exp_t;

  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [WORDS_W-1:0] req_words;
  logic [3:0] cs_on, avld_on, oe_on, we_on, gap;
  logic [4:0] cs_rd, cs_wr, avld_rd, avld_wr, oe_off, we_off, rd_len, wr_len, acc;
  logic [1:0] dv;
  logic [4:0] base;
  logic done, err, rdv, cs_n, avld_n, oe_n, we_n, woe;
  logic [DATA_W-1:0] rdata, wdata_o, mem_rdata;
  logic [RSH-1:0] maddr;

  exp_t q[$];
  int n_chk, n_fail;
  string tag;

  function automatic logic [DATA_W-1:0] memf(input logic [RSH-1:0] a);
    return (a[15:0] * 16'd7) ^ 16'h5A3C;
  endfunction

  assign mem_rdata = memf(maddr);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  amem_timing_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_words_i(req_words), .cfg_cs_on_i(cs_on), .cfg_cs_rd_off_i(cs_rd),
    .cfg_cs_wr_off_i(cs_wr), .cfg_avld_on_i(avld_on), .cfg_avld_rd_off_i(avld_rd),
    .cfg_avld_wr_off_i(avld_wr), .cfg_oe_on_i(oe_on), .cfg_oe_off_i(oe_off),
    .cfg_we_on_i(we_on), .cfg_we_off_i(we_off), .cfg_rd_len_i(rd_len),
    .cfg_wr_len_i(wr_len), .cfg_access_i(acc), .cfg_page_gap_i(gap), .cfg_div_i(dv),
    .cfg_base_i(base), .rsp_done_o(done), .rsp_err_o(err), .rdata_valid_o(rdv),
    .rdata_o(rdata), .mem_cs_n_o(cs_n), .mem_avld_n_o(avld_n), .mem_oe_n_o(oe_n),
    .mem_we_n_o(we_n), .mem_addr_o(maddr), .mem_wdata_o(wdata_o),
    .mem_wdata_oe_o(woe), .mem_rdata_i(mem_rdata)
  );

  task automatic chk(input string rq, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s) got %h exp %h at %0t", rq, tag, act, exp, $time);
    end
  endtask

  // scoreboard monitor: one expected item per clock while the queue holds items
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R3 cs", {15'd0, !cs_n}, {15'd0, e.cs});
      chk("R4 avld", {15'd0, !avld_n}, {15'd0, e.avld});
      chk("R5 oe", {15'd0, !oe_n}, {15'd0, e.oe});
      chk("R5 we", {15'd0, !we_n}, {15'd0, e.we});
      chk("R6 ready", {15'd0, req_ready}, {15'd0, e.rdy});
      chk("R6 done", {15'd0, done}, {15'd0, e.done});
      chk("R2 err", {15'd0, err}, {15'd0, e.err});
      chk("R8 rvalid", {15'd0, rdv}, {15'd0, e.rdv});
      if (e.rdv) chk("R9 rdata", rdata, e.rdata);
      chk("R10 wdata_oe", {15'd0, woe}, {15'd0, e.woe});
      if (e.woe) chk("R10 wdata", wdata_o, e.wdata);
    end
  end

  task automatic set_default();
    cs_on = 4'd1; cs_rd = 5'd9; cs_wr = 5'd8;
    avld_on = 4'd0; avld_rd = 5'd2; avld_wr = 5'd3;
    oe_on = 4'd3; oe_off = 5'd9; we_on = 4'd2; we_off = 5'd7;
    rd_len = 5'd10; wr_len = 5'd9; acc = 5'd6; gap = 4'd2; dv = 2'd0; base = 5'd5;
  endtask

  task automatic run_req(input string t, input bit wr, input logic [ADDR_W-1:0] addr,
                         input logic [DATA_W-1:0] wd, input int wm1, input bit scramble);
    bit hit;
    exp_t e;
    int d, len, n, nxt, rem, idx, pe;
    bit capp;
    logic [DATA_W-1:0] capd;
    logic [RSH-1:0] off;
    tag = t;
    hit = (addr[ADDR_W-1:RSH] == {3'b000, base});
    d = int'(dv);
    len = wr ? int'(wr_len) : int'(rd_len);
    n = len * (d + 1) + 1;
    nxt = int'(acc);
    rem = wr ? 0 : wm1 + 1;
    idx = 0;
    pe = (gap == 4'd0) ? 1 : int'(gap);
    off = addr[RSH-1:0];
    capp = 1'b0;
    capd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    req_words = WORDS_W'(wm1);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    if (!hit) begin
      e = '0; e.rdy = 1'b1; e.done = 1'b1; e.err = 1'b1;
      q.push_back(e);
      e = '0; e.rdy = 1'b1;
      q.push_back(e);
    end else begin
      for (int k = 0; k <= n; k++) begin
        int c;
        bit busy, first, cap;
        busy = (k < n);
        c = k / (d + 1);
        first = ((k % (d + 1)) == 0);
        e = '0;
        e.rdv = capp; e.rdata = capd;
        e.cs   = busy && c >= int'(cs_on)   && c < (wr ? int'(cs_wr) : int'(cs_rd));
        e.avld = busy && c >= int'(avld_on) && c < (wr ? int'(avld_wr) : int'(avld_rd));
        e.oe   = busy && !wr && c >= int'(oe_on) && c < int'(oe_off);
        e.we   = busy && wr && c >= int'(we_on) && c < int'(we_off);
        e.done = (k == n); e.rdy = !busy; e.woe = busy && wr; e.wdata = wd;
        cap = busy && first && !wr && rem > 0 && c == nxt;
        if (cap) begin
          capd = memf(off + RSH'(idx));
          nxt += pe; rem--; idx++;
        end
        capp = cap;
        q.push_back(e);
      end
      e = '0; e.rdy = 1'b1; e.rdv = capp; e.rdata = capd;
      q.push_back(e);
    end
    if (scramble) begin
      // R11: live configuration changes while the cycle runs
      cs_on = 4'd0; cs_rd = 5'd31; oe_on = 4'd0; oe_off = 5'd1; rd_len = 5'd2;
      wr_len = 5'd2; acc = 5'd0; gap = 4'd1; dv = 2'd3; we_on = 4'd0; we_off = 5'd31;
    end
    wait (q.size() == 0);
    if (scramble) set_default();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; tag = "reset";
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    req_words = '0;
    set_default();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", {15'd0, req_ready}, 16'd1);
    chk("R1 strobes", {12'd0, cs_n, avld_n, oe_n, we_n}, 16'hF);
    chk("R1 done", {14'd0, done, woe}, 16'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", {11'd0, req_ready, cs_n, avld_n, oe_n, we_n}, 16'h1F);

    run_req("R8 basic read", 1'b0, 32'h0500_0010, 16'h0, 0, 1'b0);
    run_req("R10 basic write", 1'b1, 32'h0500_0020, 16'hBEEF, 0, 1'b0);
    dv = 2'd2;
    run_req("R7 div3 read", 1'b0, 32'h0500_0100, 16'h0, 0, 1'b0);
    dv = 2'd3;
    run_req("R7 div4 write", 1'b1, 32'h0500_0104, 16'h1234, 0, 1'b0);
    dv = 2'd1;
    run_req("R9 page read div2", 1'b0, 32'h0500_0200, 16'h0, 1, 1'b0);
    dv = 2'd0;
    run_req("R9 page read tail dropped", 1'b0, 32'h0500_0300, 16'h0, 3, 1'b0);
    gap = 4'd0;
    run_req("R9 gap zero acts as one", 1'b0, 32'h0500_0400, 16'h0, 2, 1'b0);
    gap = 4'd2;
    run_req("R2 miss base", 1'b0, 32'h0600_0000, 16'h0, 0, 1'b0);
    run_req("R2 miss high bits", 1'b1, 32'h2500_0000, 16'hAAAA, 0, 1'b0);
    run_req("R2 hit region top", 1'b0, 32'h05FF_FFFF, 16'h0, 1, 1'b0);
    cs_on = 4'd5; cs_rd = 5'd5; avld_on = 4'd7; avld_rd = 5'd3; oe_on = 4'd8; oe_off = 5'd2;
    run_req("R3 R4 off not after on", 1'b0, 32'h0500_0040, 16'h0, 0, 1'b0);
    set_default();
    run_req("R11 config snapshot read", 1'b0, 32'h0500_0050, 16'h0, 1, 1'b1);
    run_req("R11 config snapshot write", 1'b1, 32'h0500_0060, 16'h7E57, 0, 1'b1);
    cs_on = 4'd0; cs_rd = 5'd1; avld_rd = 5'd1; oe_on = 4'd0; oe_off = 5'd1;
    rd_len = 5'd0; acc = 5'd0;
    run_req("R6 zero length read", 1'b0, 32'h0500_0070, 16'h0, 0, 1'b0);
    set_default();
    base = 5'd0;
    run_req("R2 base zero hit", 1'b1, 32'h00AB_CDEF, 16'h0F0F, 0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog got hang exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule